// File: doc/BRIEF.md
# Transmit Fail-Safe Message Timer

This block guards a serial bus terminal against a transmitter that runs on. It watches the encoder's transmit-active line, measures how long the current message has been on the bus, and raises a latched fail-safe flag once a message outlasts the permitted length. While the flag is up, the bus-driver enable is withdrawn, so both bus output phases are held low and no further transmission reaches the line.

Short idle stretches inside a message do not end it. Only an idle stretch longer than a small gap threshold restarts the length measurement. This applies even when the idle stretch comes from a master-reset pulse. The flag is sticky. Only an address-matched command reported by the decoder, or a low level on the master reset, clears it. With the default parameters the counters run from a 12 MHz clock: a 9216-cycle message limit (768 µs) and a 36-cycle gap threshold (3 µs).

Top module: `failsafe_timer`

## Requirements
- R1: The flag rises in the cycle after the rising edge that sees `tx_active` high with MSG_LIMIT active cycles already counted in the current message. After exactly MSG_LIMIT active cycles the flag stays low.
- R2: `drive_en` is low exactly while `fail_flag` is high, and high otherwise.
- R3: A high `addr_match` on a rising edge clears `fail_flag` after that edge.
- R4: A low `mrst_n` on a rising edge clears `fail_flag` after that edge.
- R5: An idle run of at most GAP_LIMIT consecutive cycles with `tx_active` low keeps the accumulated message length.
- R6: The message length restarts from zero on the edge of the (GAP_LIMIT+1)th consecutive idle cycle.
- R7: `mrst_n` never restarts the message length. A master-reset pulse inside a short gap leaves the message continuous.
- R8: Once set, the flag stays high through any idle time and any further transmit activity until R3 or R4 clears it.
- R9: A clear on the same edge as an overrun wins. If transmission continues with the length still beyond the limit, the flag sets again on the next active edge.
- R10: Low `rst_n` asynchronously forces `fail_flag` low and `drive_en` high, with the message length and gap counters at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_active | input | 1 | High while the encoder is shifting a word onto the bus |
| addr_match | input | 1 | Decoder pulse: valid command word with this terminal's address |
| mrst_n | input | 1 | Functional master reset, active low; clears the flag only |
| fail_flag | output | 1 | High once a message has run too long |
| drive_en | output | 1 | High when the bus drivers may follow the encoder |

## Verification
The bench builds the block with MSG_LIMIT set to 40 and GAP_LIMIT set to 4. With these values the exact overrun edge, the longest tolerated gap and the first gap that restarts the count are all reached in a few dozen cycles each. The scenarios place transmissions one cycle either side of each boundary. They place master-reset and address-match pulses inside gaps and on the overrun edge, and they pull the asynchronous reset between clock edges.

// File: rtl/ftm_pkg.sv
package ftm_pkg;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  function automatic flag_op_e pick_flag_op(input logic overrun,
                                            input logic clear_req);
    if (clear_req)    return FLAG_CLEAR;
    else if (overrun) return FLAG_SET;
    else              return FLAG_HOLD;
  endfunction

endpackage

// File: rtl/ftm_gap_tracker.sv
module ftm_gap_tracker #(
  parameter int GAP_LIMIT = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  output logic gap_expired
);

  localparam int IDLE_MAX = GAP_LIMIT + 1;
  localparam int IW       = $clog2(IDLE_MAX + 1);
  localparam logic [IW-1:0] GAP_W  = IW'(GAP_LIMIT);
  localparam logic [IW-1:0] IMAX_W = IW'(IDLE_MAX);

  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  always_comb begin
    idle_en = 1'b0;
    idle_d  = idle_q;
    if (tx_active) begin
      idle_en = (idle_q != '0);
      idle_d  = '0;
    end else if (idle_q != IMAX_W) begin
      idle_en = 1'b1;
      idle_d  = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  assign gap_expired = !tx_active && (idle_q == GAP_W);

  // R6
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= IMAX_W);

  // R5
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> idle_q == '0);

endmodule

// File: rtl/ftm_len_counter.sv
module ftm_len_counter #(
  parameter int MSG_LIMIT = 9216
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic gap_expired,
  output logic overrun
);

  localparam int LW = $clog2(MSG_LIMIT + 1);
  localparam logic [LW-1:0] LIM_W = LW'(MSG_LIMIT);

  logic [LW-1:0] len_q, len_d;
  logic          len_en;

  always_comb begin
    len_en = 1'b0;
    len_d  = len_q;
    if (gap_expired) begin
      len_en = (len_q != '0);
      len_d  = '0;
    end else if (tx_active && (len_q != LIM_W)) begin
      len_en = 1'b1;
      len_d  = len_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  assign overrun = tx_active && (len_q == LIM_W);

  // R6
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expired |=> len_q == '0);

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && len_q != LIM_W) |=> len_q == $past(len_q) + 1'b1);

  // R5
  len_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !gap_expired) |=> $stable(len_q));

endmodule

// File: rtl/ftm_flag_ctl.sv
module ftm_flag_ctl
  import ftm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic overrun,
  input  logic addr_match,
  input  logic mrst_n,
  output logic fail_q
);

  flag_op_e op;
  logic     fail_d;
  logic     fail_en;

  always_comb begin
    op      = pick_flag_op(overrun, addr_match || !mrst_n);
    fail_en = 1'b0;
    fail_d  = fail_q;
    case (op)
      FLAG_SET:   begin fail_en = !fail_q; fail_d = 1'b1; end
      FLAG_CLEAR: begin fail_en = fail_q;  fail_d = 1'b0; end
      default:    begin fail_en = 1'b0;    fail_d = fail_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  // R1
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && mrst_n && !addr_match) |=> fail_q);

  // R3
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !fail_q);

  // R4
  mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst_n |=> !fail_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && mrst_n && !addr_match) |=> fail_q);

endmodule

// File: rtl/failsafe_timer.sv
module failsafe_timer #(
  parameter int MSG_LIMIT = 9216,
  parameter int GAP_LIMIT = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic addr_match,
  input  logic mrst_n,
  output logic fail_flag,
  output logic drive_en
);

  logic gap_expired;
  logic overrun;
  logic fail_q;

  ftm_gap_tracker #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_active   (tx_active),
    .gap_expired (gap_expired)
  );

  ftm_len_counter #(.MSG_LIMIT(MSG_LIMIT)) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_active   (tx_active),
    .gap_expired (gap_expired),
    .overrun     (overrun)
  );

  ftm_flag_ctl u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .overrun    (overrun),
    .addr_match (addr_match),
    .mrst_n     (mrst_n),
    .fail_q     (fail_q)
  );

  assign fail_flag = fail_q;
  assign drive_en  = !fail_q;

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && addr_match) |=> !fail_flag);

endmodule

// File: tb/failsafe_timer_tb.sv
module failsafe_timer_tb;

  localparam int LIM = 40;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_active;
  logic addr_match;
  logic mrst_n;
  logic fail_flag;
  logic drive_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  failsafe_timer #(.MSG_LIMIT(LIM), .GAP_LIMIT(GAP)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active),
    .addr_match (addr_match),
    .mrst_n     (mrst_n),
    .fail_flag  (fail_flag),
    .drive_en   (drive_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flag(input string req, input logic exp);
    check(req, fail_flag, exp);
    check({req, " drive_en"}, drive_en, !exp);
  endtask

  task automatic run(input logic tx, input int n);
    tx_active = tx;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_addr();
    tx_active  = 1'b0;
    addr_match = 1'b1;
    @(negedge clk);
    addr_match = 1'b0;
  endtask

  task automatic settle();
    pulse_addr();
    run(1'b0, 10);
  endtask

  task automatic t_reset();
    check_flag("R10 reset", 1'b0);
  endtask

  task automatic t_overrun();
    run(1'b1, LIM);
    check_flag("R1 at limit", 1'b0);
    run(1'b1, 1);
    check_flag("R1 R2 beyond limit", 1'b1);
  endtask

  task automatic t_sticky();
    run(1'b0, 20);
    check_flag("R8 idle hold", 1'b1);
    run(1'b1, 5);
    check_flag("R8 active hold", 1'b1);
  endtask

  task automatic t_addr_clear();
    pulse_addr();
    check_flag("R3 addr clear", 1'b0);
    run(1'b0, 10);
    check_flag("R3 stays clear", 1'b0);
  endtask

  task automatic t_mrst_clear();
    run(1'b1, LIM + 1);
    check_flag("R4 pre", 1'b1);
    tx_active = 1'b0;
    mrst_n    = 1'b0;
    @(negedge clk);
    mrst_n = 1'b1;
    check_flag("R4 mrst clear", 1'b0);
    run(1'b0, 10);
  endtask

  task automatic t_short_gap();
    run(1'b1, 30);
    run(1'b0, GAP);
    run(1'b1, 10);
    check_flag("R5 gap kept length", 1'b0);
    run(1'b1, 1);
    check_flag("R5 overrun across gap", 1'b1);
    settle();
  endtask

  task automatic t_long_gap();
    run(1'b1, 30);
    run(1'b0, GAP + 1);
    run(1'b1, LIM);
    check_flag("R6 restarted count", 1'b0);
    run(1'b1, 1);
    check_flag("R6 overrun after restart", 1'b1);
    settle();
  endtask

  task automatic t_mrst_gap();
    run(1'b1, 30);
    tx_active = 1'b0;
    mrst_n    = 1'b0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    mrst_n = 1'b1;
    run(1'b1, 10);
    check_flag("R7 length kept", 1'b0);
    run(1'b1, 1);
    check_flag("R7 overrun after mrst gap", 1'b1);
    settle();
  endtask

  task automatic t_race();
    run(1'b1, LIM + 5);
    check_flag("R9 pre", 1'b1);
    addr_match = 1'b1;
    @(negedge clk);
    addr_match = 1'b0;
    check_flag("R9 clear wins", 1'b0);
    run(1'b1, 1);
    check_flag("R9 re-set", 1'b1);
  endtask

  task automatic t_async_reset();
    #1 rst_n = 1'b0;
    #0.5;
    check_flag("R10 async clear", 1'b0);
    @(negedge clk);
    rst_n     = 1'b1;
    tx_active = 1'b0;
    run(1'b0, 2);
    run(1'b1, LIM);
    check_flag("R10 counter cleared", 1'b0);
    run(1'b1, 1);
    check_flag("R10 full count needed", 1'b1);
  endtask

  initial begin
    rst_n      = 1'b0;
    tx_active  = 1'b0;
    addr_match = 1'b0;
    mrst_n     = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_overrun();
    t_sticky();
    t_addr_clear();
    t_mrst_clear();
    t_short_gap();
    t_long_gap();
    t_mrst_gap();
    t_race();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule